// File: doc/BRIEF.md
# Write-Protect Sequence Guard

This block sits in front of a page-load controller for a byte-alterable nonvolatile array and sees every decoded byte-write event as an address and a data byte. For each event it decides, in the same cycle, whether the byte may go on to the array or is part of a command that must be swallowed. It holds a protection mode bit that models nonvolatile storage: the bit loads a power-on value at reset and then changes only through command sequences.

Two command sequences share the same two-write prefix, a key byte 0xAA at the low-address pattern 0x5555 and then 0x55 at 0x2AAA. The third byte selects the sequence. Byte 0xA0 at 0x5555 completes the three-write unlock. It sets protection and opens a window for one page load, which closes when the page controller reports that programming is done. Byte 0x80 at 0x5555 continues into the six-write clear sequence. After it the bytes 0xAA at 0x5555, 0x55 at 0x2AAA and 0x20 at 0x5555 follow, and the last of them returns the block to unprotected mode. Only the low `KEY_W` address bits take part in the match.

Top module: `wp_guard`

## Requirements
- R1: After reset `prot_o` equals the parameter `POR_PROTECTED`, which defaults to 0 (unprotected). No page window is open.
- R2: When unprotected, a write that is not a command write is forwarded: `wr_allow`=1 and `wr_is_cmd`=0 in the same cycle. `wr_allow` and `wr_is_cmd` are never both 1.
- R3: Three writes (0xAA at 0x5555, 0x55 at 0x2AAA, 0xA0 at 0x5555) are each flagged `wr_is_cmd`=1 with `wr_allow`=0. From the next cycle `prot_o`=1 and the page window is open, so data writes are forwarded.
- R4: A `prog_done` pulse closes the page window. Protection stays set, and later data writes are blocked until a new unlock.
- R5: While protected with no window open, a data write gets `wr_allow`=0 and `wr_is_cmd`=0, and `prot_o` is unchanged.
- R6: The unlock sequence issued while unprotected also sets `prot_o` to 1.
- R7: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 are each flagged `wr_is_cmd`=1. From the cycle after the last of them `prot_o`=0.
- R8: Address bits at and above position `KEY_W` (default 15) are ignored when keys are matched.
- R9: A write that does not fit the expected next step returns the matcher to idle. That write is then judged from idle: it is a command write if it is 0xAA at 0x5555, and otherwise a data write allowed or blocked by the mode.
- R10: While the page window is open, every write is a data write and is forwarded, even one whose address and data equal a key.
- R11: If `prog_done` and a data write fall in the same cycle, the write is judged with the window still open. If `prog_done` coincides with the completing unlock write, the window is open afterwards.
- R12: In a cycle with `wr_valid`=0, both `wr_allow` and `wr_is_cmd` are 0 and the matcher does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the power-on mode |
| wr_valid | input | 1 | A byte-write event is present this cycle |
| wr_addr | input | ADDR_W | Byte address of the event |
| wr_data | input | 8 | Data byte of the event |
| prog_done | input | 1 | Pulse: the page controller finished its programming cycle |
| wr_allow | output | 1 | Forward this event's byte to the array |
| wr_is_cmd | output | 1 | This event is consumed as a command write |
| prot_o | output | 1 | Current protection mode (1 = protected) |

## Verification
The window close from `prog_done` can land in the same cycle as either a data write inside the window or the write that completes an unlock. The bench drives both pairings on one negative clock edge. For the first pairing it requires the coinciding byte to be forwarded and the byte after it to be blocked. For the second it requires a data write in the next cycle to be forwarded, which shows the window opened and was not closed.

// File: rtl/wp_pkg.sv
package wp_pkg;
   localparam int KEY_AW = 15;
   localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
   localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;
   localparam logic [7:0] KEY_D1   = 8'hAA;
   localparam logic [7:0] KEY_D2   = 8'h55;
   localparam logic [7:0] KEY_OPEN = 8'hA0;
   localparam logic [7:0] KEY_EXT  = 8'h80;
   localparam logic [7:0] KEY_CLR  = 8'h20;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_K1   = 3'd1,
      ST_K2   = 3'd2,
      ST_D3   = 3'd3,
      ST_D4   = 3'd4,
      ST_D5   = 3'd5
   } wp_step_e;

   typedef struct packed {
      logic k_aa;
      logic k_55;
      logic k_open;
      logic k_ext;
      logic k_clr;
   } wp_hits_t;
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match
   import wp_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int KEY_W  = 15
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   output wp_hits_t          hits
);
   localparam int PAD_W = KEY_W - KEY_AW;

   generate
      if (KEY_W < KEY_AW) begin : g_bad_key
         $error("wp_key_match: KEY_W must be at least 15");
      end
      if (KEY_W > ADDR_W) begin : g_bad_addr
         $error("wp_key_match: KEY_W must not exceed ADDR_W");
      end
   endgenerate

   logic [KEY_W-1:0] low_addr;
   logic [KEY_W-1:0] cmp_a;
   logic [KEY_W-1:0] cmp_b;

   assign low_addr = addr[KEY_W-1:0];

   generate
      if (PAD_W == 0) begin : g_exact
         assign cmp_a = KEY_ADDR_A;
         assign cmp_b = KEY_ADDR_B;
      end else begin : g_padded
         assign cmp_a = {{PAD_W{1'b0}}, KEY_ADDR_A};
         assign cmp_b = {{PAD_W{1'b0}}, KEY_ADDR_B};
      end
   endgenerate

   logic at_a;
   logic at_b;
   assign at_a = (low_addr == cmp_a);
   assign at_b = (low_addr == cmp_b);

   assign hits.k_aa   = at_a && (data == KEY_D1);
   assign hits.k_55   = at_b && (data == KEY_D2);
   assign hits.k_open = at_a && (data == KEY_OPEN);
   assign hits.k_ext  = at_a && (data == KEY_EXT);
   assign hits.k_clr  = at_a && (data == KEY_CLR);
endmodule

// File: rtl/wp_seq.sv
module wp_seq
   import wp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_valid,
   input  logic     window,
   input  wp_hits_t hits,
   output logic     cmd,
   output logic     unlock_evt,
   output logic     clear_evt
);
   wp_step_e step_q;
   wp_step_e step_d;
   logic     hit;

   always_comb begin
      step_d     = step_q;
      hit        = 1'b0;
      unlock_evt = 1'b0;
      clear_evt  = 1'b0;
      if (wr_valid && !window) begin
         case (step_q)
            ST_IDLE: if (hits.k_aa) begin step_d = ST_K1; hit = 1'b1; end
            ST_K1:   if (hits.k_55) begin step_d = ST_K2; hit = 1'b1; end
            ST_K2: begin
               if (hits.k_open) begin
                  step_d = ST_IDLE; hit = 1'b1; unlock_evt = 1'b1;
               end else if (hits.k_ext) begin
                  step_d = ST_D3; hit = 1'b1;
               end
            end
            ST_D3:   if (hits.k_aa) begin step_d = ST_D4; hit = 1'b1; end
            ST_D4:   if (hits.k_55) begin step_d = ST_D5; hit = 1'b1; end
            ST_D5: begin
               if (hits.k_clr) begin
                  step_d = ST_IDLE; hit = 1'b1; clear_evt = 1'b1;
               end
            end
            default: ;
         endcase
         if (!hit) begin
            step_d = ST_IDLE;
            if (step_q != ST_IDLE && hits.k_aa) begin
               step_d = ST_K1;
               hit    = 1'b1;
            end
         end
      end
      cmd = hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= ST_IDLE;
      else        step_q <= step_d;
   end
endmodule

// File: rtl/wp_mode.sv
module wp_mode #(
   parameter bit POR_PROTECTED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic unlock_evt,
   input  logic clear_evt,
   input  logic prog_done,
   output logic prot,
   output logic window
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot   <= POR_PROTECTED;
         window <= 1'b0;
      end else begin
         if (unlock_evt) begin
            prot   <= 1'b1;
            window <= 1'b1;
         end else begin
            if (clear_evt) prot <= 1'b0;
            if (prog_done) window <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
   import wp_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int KEY_W         = 15,
   parameter bit POR_PROTECTED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              prog_done,
   output logic              wr_allow,
   output logic              wr_is_cmd,
   output logic              prot_o
);
   wp_hits_t hits;
   logic     cmd;
   logic     unlock_evt;
   logic     clear_evt;
   logic     prot;
   logic     window;

   wp_key_match #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_match (
      .addr (wr_addr),
      .data (wr_data),
      .hits (hits)
   );

   wp_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (wr_valid),
      .window     (window),
      .hits       (hits),
      .cmd        (cmd),
      .unlock_evt (unlock_evt),
      .clear_evt  (clear_evt)
   );

   wp_mode #(.POR_PROTECTED(POR_PROTECTED)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .unlock_evt (unlock_evt),
      .clear_evt  (clear_evt),
      .prog_done  (prog_done),
      .prot       (prot),
      .window     (window)
   );

   assign wr_is_cmd = wr_valid && cmd;
   assign wr_allow  = wr_valid && !cmd && (!prot || window);
   assign prot_o    = prot;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              prog_done,
   input logic              wr_allow,
   input logic              wr_is_cmd,
   input logic              prot_o
);
   a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> (!wr_allow && !wr_is_cmd));

   a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_allow && wr_is_cmd));

   a_r2_open_when_unprot: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_is_cmd && !prot_o) |-> wr_allow);

   a_r5_mode_moves_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_o) |-> $past(wr_is_cmd));

   a_r3_rise_on_open_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_o) |-> $past(wr_data == 8'hA0));

   a_r7_fall_on_clear_key: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_o) |-> $past(wr_data == 8'h20));
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [16:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        prog_done = 1'b0;
   logic        wr_allow;
   logic        wr_is_cmd;
   logic        prot_o;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   wp_guard u0 (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .prog_done(prog_done), .wr_allow(wr_allow),
      .wr_is_cmd(wr_is_cmd), .prot_o(prot_o)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one event on the falling edge, judge the same-cycle outputs
   task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic pd,
                     input logic ea, input logic ec, input string tag);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d; prog_done = pd;
      #1;
      check(tag, {6'd0, wr_allow, wr_is_cmd}, {6'd0, ea, ec});
      @(posedge clk); #1;
      wr_valid = 1'b0; prog_done = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk); prog_done = 1'b1;
      @(posedge clk); #1; prog_done = 1'b0;
   endtask

   task automatic chk_prot(input string tag, input logic e);
      @(negedge clk); #1;
      check(tag, {7'd0, prot_o}, {7'd0, e});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      check("R1 reset prot", {7'd0, prot_o}, 8'd0);
      check("R1 reset outputs", {6'd0, wr_allow, wr_is_cmd}, 8'd0);
      rst_n = 1'b1;

      // R2: sweep of data writes while unprotected
      for (int i = 0; i < 64; i++) begin
         logic [16:0] a;
         a = 17'((i * 2053) % 131072);
         wr(a, 8'(i) ^ 8'h3C, 1'b0, 1'b1, 1'b0, "R2 unprot data");
      end

      // R6 / R3: unlock from unprotected
      wr(17'h05555, 8'hAA, 1'b0, 1'b0, 1'b1, "R3 key1");
      wr(17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R3 key2");
      wr(17'h05555, 8'hA0, 1'b0, 1'b0, 1'b1, "R3 key3");
      chk_prot("R6 unlock sets prot", 1'b1);
      wr(17'h00100, 8'h11, 1'b0, 1'b1, 1'b0, "R3 window data");
      wr(17'h05555, 8'hAA, 1'b0, 1'b1, 1'b0, "R10 key as data in window");
      wr(17'h02AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R10 key2 as data in window");
      // R11: prog_done together with a data write
      wr(17'h00102, 8'h22, 1'b1, 1'b1, 1'b0, "R11 write with done");
      wr(17'h00103, 8'h33, 1'b0, 1'b0, 1'b0, "R4 blocked after done");
      chk_prot("R4 prot stays", 1'b1);

      // R5: plain protected writes
      for (int i = 0; i < 16; i++)
         wr(17'(i * 4099), 8'(i * 7 + 1), 1'b0, 1'b0, 1'b0, "R5 protected data");
      chk_prot("R5 prot unchanged", 1'b1);

      // R9: broken sequence, breaker judged as blocked data
      wr(17'h05555, 8'hAA, 1'b0, 1'b0, 1'b1, "R9 key1");
      wr(17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R9 key2");
      wr(17'h05555, 8'h12, 1'b0, 1'b0, 1'b0, "R9 breaker blocked");
      wr(17'h05555, 8'hA0, 1'b0, 1'b0, 1'b0, "R9 stale key3 is data");
      // R9: breaker that is key1 restarts the sequence
      wr(17'h05555, 8'hAA, 1'b0, 1'b0, 1'b1, "R9 key1 a");
      wr(17'h05555, 8'hAA, 1'b0, 1'b0, 1'b1, "R9 key1 restart");
      wr(17'h02AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R9 key2 after restart");
      // R11: prog_done on the completing unlock write
      wr(17'h05555, 8'hA0, 1'b1, 1'b0, 1'b1, "R11 key3 with done");
      wr(17'h00200, 8'h44, 1'b0, 1'b1, 1'b0, "R11 window opened");
      done_pulse();
      wr(17'h00201, 8'h45, 1'b0, 1'b0, 1'b0, "R4 closed by done");

      // R8 / R7: clear sequence with high address bits set
      wr(17'h1D555, 8'hAA, 1'b0, 1'b0, 1'b1, "R8 clr1 high bits");
      wr(17'h0AAAA, 8'h55, 1'b0, 1'b0, 1'b1, "R8 clr2 high bits");
      wr(17'h15555, 8'h80, 1'b0, 1'b0, 1'b1, "R7 clr3");
      chk_prot("R7 still prot mid sequence", 1'b1);
      wr(17'h0D555, 8'hAA, 1'b0, 1'b0, 1'b1, "R7 clr4");
      wr(17'h1AAAA, 8'h55, 1'b0, 1'b0, 1'b1, "R7 clr5");
      wr(17'h05555, 8'h20, 1'b0, 1'b0, 1'b1, "R7 clr6");
      chk_prot("R7 cleared", 1'b0);
      wr(17'h00300, 8'h66, 1'b0, 1'b1, 1'b0, "R7 data after clear");

      // R12: idle cycle shows nothing and does not advance the matcher
      @(negedge clk);
      wr_addr = 17'h05555; wr_data = 8'hAA; wr_valid = 1'b0;
      #1;
      check("R12 idle outputs", {6'd0, wr_allow, wr_is_cmd}, 8'd0);
      wr(17'h02AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R12 no advance");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule